// File: doc/BRIEF.md
# Exception and Vector Controller

This block watches a processor's memory stage for two faults, and for a software interrupt request. The first fault is an out-of-range data access. The second is a pop from an empty stack. When one of these events is seen, the block does four things:

- It raises a flush request in that same cycle.
- For the two faults only, it records the address of the offending instruction in an exception program counter.
- It reads a 32-bit handler address from two consecutive 16-bit words in a small fixed region of low instruction memory.
- It hands that address to the fetch stage with a one-cycle load strobe.

Each cause has its own pair of vector words. The pipeline itself, the memories and the decoder sit outside this block. The instruction memory is reached through a read port with one cycle of latency. Events that arrive while a vector fetch is in progress are dropped, because the pipeline is already being flushed.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted, `flush`, `pc_load`, `imem_rd_en` and `busy` are 0 and `epc` is 0. A reset during a vector fetch abandons it, and no `pc_load` follows.
- R2: An address fault is raised when `mem_valid` is 1 and `mem_addr` is strictly greater than 0xFF00. Address 0xFF00 itself, and any address while `mem_valid` is 0, raise nothing.
- R3: A stack fault is raised only when `pop_req` and `stack_empty` are both 1. A pop with a non-empty stack, or an empty stack without a pop, raises nothing.
- R4: On a stack fault or an address fault, `epc` takes the value of `instr_pc` at the clock edge that ends the detection cycle. A software interrupt leaves `epc` unchanged.
- R5: The vector word pair read is as follows: words 2 and 3 for a stack fault, words 4 and 5 for an address fault, words 6 and 7 for an interrupt with `int_sel`=0 (index 0), and words 8 and 9 for `int_sel`=1 (index 2). The lower-numbered word is addressed one cycle after detection, and the higher-numbered word two cycles after detection.
- R6: `pc_load` is high for exactly one cycle, three cycles after the detection cycle. During that cycle `pc_value` equals {word[slot], word[slot+1]}, with the first word as bits 31:16.
- R7: Priority when several events occur together is stack fault, then address fault, then software interrupt.
- R8: While `busy` is 1, new events raise no flush, do not change `epc`, and do not alter the vector being fetched.
- R9: With no event present, `flush` stays 0 and no instruction-memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_pc | input | 32 | Address of the instruction in the memory stage |
| mem_valid | input | 1 | A data-memory access is being made |
| mem_addr | input | 20 | Data-memory word address of that access |
| pop_req | input | 1 | The instruction attempts a pop |
| stack_empty | input | 1 | The stack holds no entries |
| int_req | input | 1 | Software interrupt request |
| int_sel | input | 1 | Interrupt index select: 0 means index 0, 1 means index 2 |
| imem_rd_en | output | 1 | Instruction-memory read enable |
| imem_rd_addr | output | 8 | Instruction-memory word address |
| imem_rd_data | input | 16 | Read data, valid the cycle after the address |
| flush | output | 1 | Flush request, combinational in the detection cycle |
| busy | output | 1 | A vector fetch is in progress |
| pc_load | output | 1 | One-cycle strobe to load the program counter |
| pc_value | output | 32 | Handler address, valid while `pc_load` is 1 |
| epc | output | 32 | Exception program counter |

## Verification
The detector is driven with the following patterns:

- Address probes on both sides of the 0xFF00 limit, and at the very top of the data space, with the access strobe both on and off. These separate a strict comparison from an inclusive one, and show that the strobe gates the comparison.
- Pops against a full and an empty stack, and an empty stack with no pop. These show that both conditions are needed.
- Both interrupt indices and each fault alone. These tell the four vector pairs apart by the read addresses and by the assembled `pc_value`, so a swapped slot, a swapped half or an off-by-one address shows up.
- Combined events. These pin down the priority order.
- An event injected while busy, and a reset in the middle of a fetch. These show that both are handled as dropped work.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_STACK = 2'd1,
      CAUSE_ADDR  = 2'd2,
      CAUSE_SWI   = 2'd3
   } cause_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_HI   = 2'd1,
      FS_LO   = 2'd2,
      FS_LOAD = 2'd3
   } fetch_st_e;

   function automatic logic is_fault(cause_e c);
      return (c == CAUSE_STACK) || (c == CAUSE_ADDR);
   endfunction

endpackage

// File: rtl/exc_detect.sv
module exc_detect
   import exc_vec_pkg::*;
#(
   parameter int DADDR_W  = 20,
   parameter int IMEM_AW  = 8,
   parameter int ADDR_LIM = 32'hFF00,
   parameter int ES_SLOT  = 2,
   parameter int IA_SLOT  = 4,
   parameter int SWI_BASE = 6
) (
   input  logic               pop_req,
   input  logic               stack_empty,
   input  logic               mem_valid,
   input  logic [DADDR_W-1:0] mem_addr,
   input  logic               int_req,
   input  logic               int_sel,
   output cause_e             cause,
   output logic [IMEM_AW-1:0] slot
);

   localparam logic [DADDR_W-1:0] LIM_V   = DADDR_W'(ADDR_LIM);
   localparam logic [IMEM_AW-1:0] ES_A    = IMEM_AW'(ES_SLOT);
   localparam logic [IMEM_AW-1:0] IA_A    = IMEM_AW'(IA_SLOT);
   localparam logic [IMEM_AW-1:0] SWI0_A  = IMEM_AW'(SWI_BASE);
   localparam logic [IMEM_AW-1:0] SWI2_A  = IMEM_AW'(SWI_BASE + 2);

   logic stack_hit;
   logic addr_hit;

   assign stack_hit = pop_req && stack_empty;
   assign addr_hit  = mem_valid && (mem_addr > LIM_V);

   always_comb begin
      cause = CAUSE_NONE;
      slot  = '0;
      if (stack_hit) begin
         cause = CAUSE_STACK;
         slot  = ES_A;
      end else if (addr_hit) begin
         cause = CAUSE_ADDR;
         slot  = IA_A;
      end else if (int_req) begin
         cause = CAUSE_SWI;
         slot  = int_sel ? SWI2_A : SWI0_A;
      end
   end

endmodule

// File: rtl/exc_epc.sv
module exc_epc #(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [PC_W-1:0] pc_in,
   output logic [PC_W-1:0] epc
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         epc <= '0;
      else if (capture)
         epc <= pc_in;
   end

endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
   import exc_vec_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int IMEM_AW  = 8,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [IMEM_AW-1:0]  slot,
   output logic                rd_en,
   output logic [IMEM_AW-1:0]  rd_addr,
   input  logic [WORD_W-1:0]   rd_data,
   output logic                busy,
   output logic                pc_load,
   output logic [2*WORD_W-1:0] pc_value
);

   localparam int VEC_W = 2 * WORD_W;

   fetch_st_e          st_q;
   logic [IMEM_AW-1:0] base_q;
   logic [WORD_W-1:0]  first_q;
   logic [VEC_W-1:0]   joined;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= FS_IDLE;
         base_q  <= '0;
         first_q <= '0;
      end else begin
         unique case (st_q)
            FS_IDLE: if (start) begin
               st_q   <= FS_HI;
               base_q <= slot;
            end
            FS_HI:   st_q <= FS_LO;
            FS_LO: begin
               st_q    <= FS_LOAD;
               first_q <= rd_data;
            end
            FS_LOAD: st_q <= FS_IDLE;
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != FS_IDLE);
   assign rd_en   = (st_q == FS_HI) || (st_q == FS_LO);
   assign rd_addr = (st_q == FS_LO) ? base_q + IMEM_AW'(1) : base_q;
   assign pc_load = (st_q == FS_LOAD);

   generate
      if (HI_FIRST) begin : g_hi_first
         assign joined = {first_q, rd_data};
      end else begin : g_lo_first
         assign joined = {rd_data, first_q};
      end
   endgenerate

   assign pc_value = pc_load ? joined : '0;

endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
   import exc_vec_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int DADDR_W  = 20,
   parameter int IMEM_AW  = 8,
   parameter int ADDR_LIM = 32'hFF00,
   parameter int ES_SLOT  = 2,
   parameter int IA_SLOT  = 4,
   parameter int SWI_BASE = 6,
   parameter bit HI_FIRST = 1'b1,
   localparam int PC_W    = 2 * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PC_W-1:0]    instr_pc,
   input  logic               mem_valid,
   input  logic [DADDR_W-1:0] mem_addr,
   input  logic               pop_req,
   input  logic               stack_empty,
   input  logic               int_req,
   input  logic               int_sel,
   output logic               imem_rd_en,
   output logic [IMEM_AW-1:0] imem_rd_addr,
   input  logic [WORD_W-1:0]  imem_rd_data,
   output logic               flush,
   output logic               busy,
   output logic               pc_load,
   output logic [PC_W-1:0]    pc_value,
   output logic [PC_W-1:0]    epc
);

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("exc_vector_ctrl: WORD_W too small");
      end
      if ((SWI_BASE + 3) >= (1 << IMEM_AW)) begin : g_bad_slot
         $error("exc_vector_ctrl: vector slots exceed instruction address space");
      end
      if (ADDR_LIM >= (1 << DADDR_W)) begin : g_bad_lim
         $error("exc_vector_ctrl: address limit outside data address space");
      end
   endgenerate

   cause_e             cause;
   logic [IMEM_AW-1:0] slot;
   logic               take;

   exc_detect #(
      .DADDR_W (DADDR_W),
      .IMEM_AW (IMEM_AW),
      .ADDR_LIM(ADDR_LIM),
      .ES_SLOT (ES_SLOT),
      .IA_SLOT (IA_SLOT),
      .SWI_BASE(SWI_BASE)
   ) u_detect (
      .pop_req    (pop_req),
      .stack_empty(stack_empty),
      .mem_valid  (mem_valid),
      .mem_addr   (mem_addr),
      .int_req    (int_req),
      .int_sel    (int_sel),
      .cause      (cause),
      .slot       (slot)
   );

   assign take  = !busy && (cause != CAUSE_NONE);
   assign flush = take;

   exc_epc #(
      .PC_W(PC_W)
   ) u_epc (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(take && is_fault(cause)),
      .pc_in  (instr_pc),
      .epc    (epc)
   );

   exc_vec_fetch #(
      .WORD_W  (WORD_W),
      .IMEM_AW (IMEM_AW),
      .HI_FIRST(HI_FIRST)
   ) u_fetch (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (take),
      .slot    (slot),
      .rd_en   (imem_rd_en),
      .rd_addr (imem_rd_addr),
      .rd_data (imem_rd_data),
      .busy    (busy),
      .pc_load (pc_load),
      .pc_value(pc_value)
   );

endmodule

module exc_vector_ctrl_chk #(
   parameter int WORD_W   = 16,
   parameter int DADDR_W  = 20,
   parameter int IMEM_AW  = 8,
   parameter int ADDR_LIM = 32'hFF00,
   localparam int PC_W    = 2 * WORD_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PC_W-1:0]    instr_pc,
   input logic               mem_valid,
   input logic [DADDR_W-1:0] mem_addr,
   input logic               pop_req,
   input logic               stack_empty,
   input logic               int_req,
   input logic               imem_rd_en,
   input logic               flush,
   input logic               busy,
   input logic               pc_load,
   input logic [PC_W-1:0]    epc
);

   localparam logic [DADDR_W-1:0] LIM_V = DADDR_W'(ADDR_LIM);

   // R6
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> !pc_load);

   // R6
   flush_to_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> ##3 pc_load);

   // R4
   epc_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && pop_req && stack_empty) |=> (epc == $past(instr_pc)));

   // R4
   epc_swi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && int_req && !(pop_req && stack_empty)
       && !(mem_valid && (mem_addr > LIM_V))) |=> $stable(epc));

   // R8
   busy_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !flush);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !imem_rd_en);

endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk #(
   .WORD_W  (WORD_W),
   .DADDR_W (DADDR_W),
   .IMEM_AW (IMEM_AW),
   .ADDR_LIM(ADDR_LIM)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_pc   (instr_pc),
   .mem_valid  (mem_valid),
   .mem_addr   (mem_addr),
   .pop_req    (pop_req),
   .stack_empty(stack_empty),
   .int_req    (int_req),
   .imem_rd_en (imem_rd_en),
   .flush      (flush),
   .busy       (busy),
   .pc_load    (pc_load),
   .epc        (epc)
);

// File: tb/tb_exc_vector_ctrl.sv
module tb_exc_vector_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] instr_pc;
   logic        mem_valid;
   logic [19:0] mem_addr;
   logic        pop_req;
   logic        stack_empty;
   logic        int_req;
   logic        int_sel;
   logic        imem_rd_en;
   logic [7:0]  imem_rd_addr;
   logic [15:0] imem_rd_data;
   logic        flush;
   logic        busy;
   logic        pc_load;
   logic [31:0] pc_value;
   logic [31:0] epc;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_epc;

   always #4 clk = ~clk;

   exc_vector_ctrl dut (
      .clk(clk), .rst_n(rst_n), .instr_pc(instr_pc), .mem_valid(mem_valid),
      .mem_addr(mem_addr), .pop_req(pop_req), .stack_empty(stack_empty),
      .int_req(int_req), .int_sel(int_sel), .imem_rd_en(imem_rd_en),
      .imem_rd_addr(imem_rd_addr), .imem_rd_data(imem_rd_data), .flush(flush),
      .busy(busy), .pc_load(pc_load), .pc_value(pc_value), .epc(epc)
   );

   function automatic logic [15:0] vword(int i);
      return 16'(i * 16'h0301 + 16'h8C4B);
   endfunction

   always_ff @(posedge clk) begin
      if (imem_rd_en) imem_rd_data <= vword(int'(imem_rd_addr));
   end

   typedef struct packed {
      logic        pop;
      logic        empty;
      logic        mval;
      logic [19:0] maddr;
      logic        ireq;
      logic        isel;
      logic [31:0] pc;
      logic        fl;
      logic [7:0]  slot;
      logic        fault;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R3 empty-stack pop
      '{1'b1, 1'b1, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h0000_0101, 1'b1, 8'd2, 1'b1, 4'd3},
      // R3 pop with non-empty stack
      '{1'b1, 1'b0, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h0000_0102, 1'b0, 8'd0, 1'b0, 4'd3},
      // R2 just above limit
      '{1'b0, 1'b0, 1'b1, 20'h0FF01, 1'b0, 1'b0, 32'h0000_0203, 1'b1, 8'd4, 1'b1, 4'd2},
      // R2 exactly at limit
      '{1'b0, 1'b0, 1'b1, 20'h0FF00, 1'b0, 1'b0, 32'h0000_0204, 1'b0, 8'd0, 1'b0, 4'd2},
      // R2 high address without access strobe
      '{1'b0, 1'b0, 1'b0, 20'hFFFFF, 1'b0, 1'b0, 32'h0000_0205, 1'b0, 8'd0, 1'b0, 4'd2},
      // R2 far above limit
      '{1'b0, 1'b0, 1'b1, 20'h12345, 1'b0, 1'b0, 32'h0000_0306, 1'b1, 8'd4, 1'b1, 4'd2},
      // R5 interrupt index 0
      '{1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 1'b0, 32'h0000_0407, 1'b1, 8'd6, 1'b0, 4'd5},
      // R5 interrupt index 2
      '{1'b0, 1'b0, 1'b0, 20'h00000, 1'b1, 1'b1, 32'h0000_0508, 1'b1, 8'd8, 1'b0, 4'd5},
      // R7 stack fault beats address fault
      '{1'b1, 1'b1, 1'b1, 20'hFFFFF, 1'b0, 1'b0, 32'h0000_0609, 1'b1, 8'd2, 1'b1, 4'd7},
      // R7 address fault beats interrupt
      '{1'b0, 1'b0, 1'b1, 20'h0FF80, 1'b1, 1'b1, 32'h0000_070A, 1'b1, 8'd4, 1'b1, 4'd7},
      // R3 empty stack without pop
      '{1'b0, 1'b1, 1'b0, 20'h00000, 1'b0, 1'b0, 32'h0000_080B, 1'b0, 8'd0, 1'b0, 4'd3},
      // R9 no event
      '{1'b0, 1'b0, 1'b0, 20'h00ABC, 1'b0, 1'b0, 32'h0000_090C, 1'b0, 8'd0, 1'b0, 4'd9}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle_inputs();
      mem_valid = 1'b0; mem_addr = '0; pop_req = 1'b0; stack_empty = 1'b0;
      int_req = 1'b0; int_sel = 1'b0; instr_pc = 32'hDEAD_0000;
   endtask

   task automatic drive(input vec_t v);
      pop_req = v.pop; stack_empty = v.empty; mem_valid = v.mval;
      mem_addr = v.maddr; int_req = v.ireq; int_sel = v.isel; instr_pc = v.pc;
   endtask

   task automatic run_vec(input vec_t v);
      string rq;
      logic [31:0] exp_pc;
      rq = $sformatf("R%0d", v.req);
      @(negedge clk);
      drive(v);
      #2;
      chk(flush == v.fl, rq, "flush", 32'(flush), 32'(v.fl));
      @(negedge clk);
      idle_inputs();
      if (v.fault) exp_epc = v.pc;
      chk(epc == exp_epc, "R4", "epc", epc, exp_epc);
      if (v.fl) begin
         chk(imem_rd_en && imem_rd_addr == v.slot, "R5", "first vector addr",
             32'(imem_rd_addr), 32'(v.slot));
         @(negedge clk);
         chk(imem_rd_en && imem_rd_addr == v.slot + 8'd1 && !pc_load, "R5",
             "second vector addr", 32'(imem_rd_addr), 32'(v.slot + 8'd1));
         @(negedge clk);
         exp_pc = {vword(int'(v.slot)), vword(int'(v.slot) + 1)};
         chk(pc_load && pc_value == exp_pc, "R6", "pc_value at load", pc_value, exp_pc);
         @(negedge clk);
         chk(!pc_load && !busy, "R6", "load single pulse", 32'(pc_load), 32'h0);
      end else begin
         chk(!busy && !imem_rd_en, "R9", "no fetch started", 32'(imem_rd_en), 32'h0);
      end
   endtask

   bit done = 1'b0;

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] exp_pc;
      idle_inputs();
      exp_epc = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1 reset state
      chk(!flush && !pc_load && !imem_rd_en && !busy && epc == 32'h0, "R1",
          "reset state", epc, 32'h0);

      foreach (VECS[i]) run_vec(VECS[i]);

      // R8 events during a fetch are ignored
      @(negedge clk);
      int_req = 1'b1; int_sel = 1'b0; instr_pc = 32'h0000_0A01;
      @(negedge clk);
      int_req = 1'b0;
      pop_req = 1'b1; stack_empty = 1'b1; instr_pc = 32'h0000_0A02;
      #2;
      chk(!flush, "R8", "flush while busy", 32'(flush), 32'h0);
      @(negedge clk);
      chk(epc == exp_epc, "R8", "epc while busy", epc, exp_epc);
      @(negedge clk);
      idle_inputs();
      exp_pc = {vword(6), vword(7)};
      chk(pc_load && pc_value == exp_pc, "R8", "vector kept", pc_value, exp_pc);
      @(negedge clk);
      chk(!busy, "R8", "idle after fetch", 32'(busy), 32'h0);

      // R1 reset in the middle of a fetch
      @(negedge clk);
      mem_valid = 1'b1; mem_addr = 20'hFFF00; instr_pc = 32'h0000_0B01;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(negedge clk);
      chk(!busy && !imem_rd_en && epc == 32'h0, "R1", "reset aborts fetch",
          epc, 32'h0);
      rst_n = 1'b1;
      exp_epc = '0;
      repeat (3) begin
         @(negedge clk);
         chk(!pc_load, "R1", "no load after reset", 32'(pc_load), 32'h0);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule